// File: doc/BRIEF.md
# NAND Boot Image Loader with Bad-Block Skipping

This block is a boot-time state machine that copies an image of a given length from NAND flash into memory. It receives a byte offset into the flash, an image length in bytes and a destination base address. It then walks the flash one erase block at a time. For every page it sends the read command byte sequence and asks an external subpage sequencer for an error-corrected page. That sequencer streams the data words back and reports whether the read succeeded, together with the first two free spare bytes of the first subpage. The loader turns each streamed word into a write on a simple memory port.

Bad blocks are found during the copy. A block is bad if one of its pages carries a spare marker, or if none of its page reads succeeded. A bad block is skipped: the next block is loaded to the same destination and the image length is not reduced. The flash source always moves on by a full block. A failed page read inside a block that is otherwise good ends the load with an error. The load also ends if the source page number reaches the end of the device. Every load ends with a one-cycle done pulse and a status code.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset, busy, done, fl_valid, sq_req and mem_we are all low.
- R2: Each page read sends seven bytes. The first is command 0x00 with fl_is_cmd=1. Then come two 0x00 address bytes, then page-number bits 7:0, 15:8 and 23:16 as address bytes (fl_is_cmd=0), and last the command 0x30 with fl_is_cmd=1. A byte is held stable until fl_ready accepts it, and no page data is requested while a byte is pending.
- R3: The first page read is page img_offset/2048, and pages inside a block are read in ascending order. Word k of the page at index i within a block is written to the block destination + 2048*i + 4*k, and only while sq_req is high.
- R4: A page whose read succeeded (sq_ok=1) and whose sq_spare0 or sq_spare1 is not 0xFF marks its block bad. No further page of that block is read. Spare bytes of failed reads are ignored.
- R5: A block in which no page read succeeded is bad.
- R6: After a bad block, the destination address and the remaining image length stay unchanged. The source page always moves on by 64 from the first page read in the block, whether the block was good or bad.
- R7: A block that is not bad but contains a failed read ends the load with status 1 (read error). No further page is read.
- R8: Each block reads min(64, remaining pages) pages, where remaining pages is the remaining length divided by 2048, rounded up. The load ends with status 0 when the remaining length reaches zero. A zero length finishes with status 0 and reads no page.
- R9: No page number at or above MAX_PAGES is ever read. Reaching such a page ends the load with status 2 (source exhausted).
- R10: done is a single-cycle pulse, and status is valid while done is high. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only when idle) |
| img_offset | input | 32 | Byte offset of the image in flash |
| img_size | input | 32 | Image length in bytes |
| dst_base | input | 32 | Destination byte address in memory |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| status | output | 2 | 0 success, 1 read error, 2 source exhausted |
| fl_valid | output | 1 | Command/address byte valid |
| fl_is_cmd | output | 1 | 1 = command byte, 0 = address byte |
| fl_byte | output | 8 | Command/address byte value |
| fl_ready | input | 1 | Flash side accepts the current byte |
| sq_req | output | 1 | Request a corrected page read; held until sq_done |
| sq_word_valid | input | 1 | Page data word valid |
| sq_word | input | 32 | Page data word |
| sq_done | input | 1 | Page read finished (one cycle) |
| sq_ok | input | 1 | Page read succeeded (with sq_done) |
| sq_spare0 | input | 8 | Free spare byte 0 of first subpage |
| sq_spare1 | input | 8 | Free spare byte 1 of first subpage |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The hardest cases to reach are the block-level decisions that depend on the history of a whole block. A marker can appear partway through a block, every page of a block can fail, a good page can be mixed with a failed one, and the end of the flash can fall inside a block. The bench reaches these states with a per-page table in its flash model. The table sets which page numbers fail and which carry a marker in either spare byte, and it places them at a block's middle, its start, or just below the page limit. A bench-only override of that limit keeps the exhaustion case short. Each load's log of page numbers and first-word addresses is then compared with the sequence predicted from the requirements.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLK,
        ST_PCHK,
        ST_PCMD,
        ST_PRD,
        ST_BEVAL,
        ST_FIN
    } ld_state_t;

    typedef enum logic [1:0] {
        LD_OK    = 2'd0,
        LD_RDERR = 2'd1,
        LD_NOSRC = 2'd2
    } ld_status_t;

    typedef struct packed {
        logic any_good;
        logic any_err;
        logic marked;
    } blk_flags_t;

    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] CMD_READ_GO = 8'h30;
    localparam logic [7:0] SPARE_CLEAN = 8'hFF;

    function automatic logic spare_marked(input logic [7:0] s0, input logic [7:0] s1);
        return (s0 != SPARE_CLEAN) || (s1 != SPARE_CLEAN);
    endfunction

endpackage

// File: rtl/nbl_cmd_seq.sv
module nbl_cmd_seq #(
    parameter int ROW_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [8*ROW_BYTES-1:0] page,
    input  logic                   fl_ready,
    output logic                   fl_valid,
    output logic                   fl_is_cmd,
    output logic [7:0]             fl_byte,
    output logic                   seq_done
);
    import nbl_pkg::*;

    localparam int COL_BYTES = 2;
    localparam int NBYTES    = ROW_BYTES + COL_BYTES + 2;
    localparam int IDX_W     = $clog2(NBYTES);
    localparam int ROW_FIRST = 1 + COL_BYTES;

    logic                   active;
    logic [IDX_W-1:0]       idx;
    logic [8*ROW_BYTES-1:0] pg_q;
    logic [7:0]             row_b [ROW_BYTES];

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
        assign row_b[g] = pg_q[8*g +: 8];
    end

    always_comb begin
        fl_valid  = active;
        fl_is_cmd = (idx == '0) || (idx == IDX_W'(NBYTES - 1));
        if (idx == '0)
            fl_byte = CMD_READ;
        else if (idx == IDX_W'(NBYTES - 1))
            fl_byte = CMD_READ_GO;
        else if (idx < IDX_W'(ROW_FIRST))
            fl_byte = 8'h00;
        else
            fl_byte = row_b[idx - IDX_W'(ROW_FIRST)];
        seq_done = active && fl_ready && (idx == IDX_W'(NBYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            pg_q   <= '0;
        end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
            pg_q   <= page;
        end else if (active && fl_ready) begin
            if (idx == IDX_W'(NBYTES - 1))
                active <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/nbl_page_wr.sv
module nbl_page_wr #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PAGE_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [ADDR_W-1:0] base,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int WB   = DATA_W / 8;
    localparam int WSH  = $clog2(WB);
    localparam int WI_W = $clog2(PAGE_BYTES / WB);

    logic [WI_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else if (word_valid)
            cnt <= cnt + 1'b1;
    end

    assign mem_we    = active && word_valid;
    assign mem_addr  = base + (ADDR_W'(cnt) << WSH);
    assign mem_wdata = word;

endmodule

// File: rtl/nand_boot_loader.sv
module nand_boot_loader #(
    parameter int PAGE_BYTES  = 2048,
    parameter int BLOCK_PAGES = 64,
    parameter int MAX_PAGES   = 524288,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ROW_BYTES   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] img_offset,
    input  logic [ADDR_W-1:0] img_size,
    input  logic [ADDR_W-1:0] dst_base,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              fl_valid,
    output logic              fl_is_cmd,
    output logic [7:0]        fl_byte,
    input  logic              fl_ready,
    output logic              sq_req,
    input  logic              sq_word_valid,
    input  logic [DATA_W-1:0] sq_word,
    input  logic              sq_done,
    input  logic              sq_ok,
    input  logic [7:0]        sq_spare0,
    input  logic [7:0]        sq_spare1,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import nbl_pkg::*;

    localparam int PG_SH = $clog2(PAGE_BYTES);
    localparam int BP_W  = $clog2(BLOCK_PAGES) + 1;
    localparam int PN_W  = 8 * ROW_BYTES;
    localparam logic [ADDR_W-1:0] BLK_BYTES_V = ADDR_W'(PAGE_BYTES * BLOCK_PAGES);
    localparam logic [ADDR_W-1:0] PG_BYTES_V  = ADDR_W'(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] BLK_PG_V    = ADDR_W'(BLOCK_PAGES);
    localparam logic [ADDR_W-1:0] MAX_PG_V    = ADDR_W'(MAX_PAGES);

    ld_state_t         st;
    ld_status_t        stat_q;
    blk_flags_t        flags;
    logic [ADDR_W-1:0] blk_pg, cur_pg, dst, pg_dst, bytes_left;
    logic [BP_W-1:0]   pgs_rem;
    logic [ADDR_W-1:0] blk_bytes, blk_pgs_w, start_pg;
    logic              src_end, cmd_go, cmd_done, mark_now;

    assign start_pg  = img_offset >> PG_SH;
    assign blk_bytes = (bytes_left > BLK_BYTES_V) ? BLK_BYTES_V : bytes_left;
    assign blk_pgs_w = (blk_bytes + PG_BYTES_V - 1'b1) >> PG_SH;
    assign src_end   = cur_pg >= MAX_PG_V;
    assign cmd_go    = (st == ST_PCHK) && !src_end;
    assign mark_now  = sq_ok && spare_marked(sq_spare0, sq_spare1);

    assign busy   = st != ST_IDLE;
    assign done   = st == ST_FIN;
    assign status = stat_q;
    assign sq_req = st == ST_PRD;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            stat_q     <= LD_OK;
            flags      <= '0;
            blk_pg     <= '0;
            cur_pg     <= '0;
            dst        <= '0;
            pg_dst     <= '0;
            bytes_left <= '0;
            pgs_rem    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    blk_pg     <= start_pg;
                    dst        <= dst_base;
                    bytes_left <= img_size;
                    st         <= ST_BLK;
                end
                ST_BLK: begin
                    if (bytes_left == '0) begin
                        stat_q <= LD_OK;
                        st     <= ST_FIN;
                    end else begin
                        cur_pg  <= blk_pg;
                        pg_dst  <= dst;
                        pgs_rem <= BP_W'(blk_pgs_w);
                        flags   <= '0;
                        st      <= ST_PCHK;
                    end
                end
                ST_PCHK: begin
                    if (src_end) begin
                        stat_q <= LD_NOSRC;
                        st     <= ST_FIN;
                    end else begin
                        st <= ST_PCMD;
                    end
                end
                ST_PCMD: if (cmd_done) st <= ST_PRD;
                ST_PRD: if (sq_done) begin
                    flags.any_good <= flags.any_good | sq_ok;
                    flags.any_err  <= flags.any_err | !sq_ok;
                    flags.marked   <= flags.marked | mark_now;
                    cur_pg         <= cur_pg + 1'b1;
                    pg_dst         <= pg_dst + PG_BYTES_V;
                    pgs_rem        <= pgs_rem - 1'b1;
                    st <= (pgs_rem == BP_W'(1) || mark_now) ? ST_BEVAL : ST_PCHK;
                end
                ST_BEVAL: begin
                    blk_pg <= blk_pg + BLK_PG_V;
                    if (flags.marked || !flags.any_good) begin
                        st <= ST_BLK;
                    end else if (flags.any_err) begin
                        stat_q <= LD_RDERR;
                        st     <= ST_FIN;
                    end else begin
                        dst        <= dst + blk_bytes;
                        bytes_left <= bytes_left - blk_bytes;
                        st         <= ST_BLK;
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    nbl_cmd_seq #(.ROW_BYTES(ROW_BYTES)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .go       (cmd_go),
        .page     (cur_pg[PN_W-1:0]),
        .fl_ready (fl_ready),
        .fl_valid (fl_valid),
        .fl_is_cmd(fl_is_cmd),
        .fl_byte  (fl_byte),
        .seq_done (cmd_done)
    );

    nbl_page_wr #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .active    (sq_req),
        .base      (pg_dst),
        .word_valid(sq_word_valid),
        .word      (sq_word),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/nbl_chk.sv
module nbl_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       fl_valid,
    input logic       fl_ready,
    input logic       fl_is_cmd,
    input logic [7:0] fl_byte,
    input logic       sq_req,
    input logic       mem_we
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !fl_valid && !sq_req && !mem_we));

    // R2
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_byte) && $stable(fl_is_cmd)));

    // R2
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        fl_valid |-> !sq_req);

    // R3
    write_window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> sq_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_valid && !mem_we));
endmodule

bind nand_boot_loader nbl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .fl_valid (fl_valid),
    .fl_ready (fl_ready),
    .fl_is_cmd(fl_is_cmd),
    .fl_byte  (fl_byte),
    .sq_req   (sq_req),
    .mem_we   (mem_we)
);

// File: tb/sim_nand_boot_loader.sv
`timescale 1ns/1ps
module sim_nand_boot_loader;
    localparam int NW  = 4;
    localparam int NPG = 512;
    localparam int LOGN = 160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] img_offset = '0, img_size = '0, dst_base = '0;
    logic        busy, done;
    logic [1:0]  status;
    logic        fl_valid, fl_is_cmd;
    logic [7:0]  fl_byte;
    logic        fl_ready = 1'b1;
    logic        sq_req;
    logic        sq_word_valid = 1'b0;
    logic [31:0] sq_word = '0;
    logic        sq_done = 1'b0, sq_ok = 1'b0;
    logic [7:0]  sq_spare0 = 8'hFF, sq_spare1 = 8'hFF;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;

    always #5 clk = ~clk;

    nand_boot_loader #(.MAX_PAGES(NPG)) u0 (
        .clk(clk), .rst(rst), .start(start), .img_offset(img_offset),
        .img_size(img_size), .dst_base(dst_base), .busy(busy), .done(done),
        .status(status), .fl_valid(fl_valid), .fl_is_cmd(fl_is_cmd),
        .fl_byte(fl_byte), .fl_ready(fl_ready), .sq_req(sq_req),
        .sq_word_valid(sq_word_valid), .sq_word(sq_word), .sq_done(sq_done),
        .sq_ok(sq_ok), .sq_spare0(sq_spare0), .sq_spare1(sq_spare1),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0, errors = 0;
    bit fail_pg [NPG];
    bit mark0 [NPG];
    bit mark1 [NPG];
    bit stall_en = 0, tog = 0;
    logic [7:0] bq [7];
    bit bc [7];
    int bidx = 0, rcnt = 0, n_log = 0, seq_bad = 0;
    int page_log [LOGN];
    logic [31:0] addr_log [LOGN];
    logic [31:0] first_addr;
    int cur;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // flash and subpage sequencer model
    initial begin
        forever begin
            @(negedge clk);
            tog = !tog;
            fl_ready = !stall_en || tog;
            #1;
            if (fl_valid && fl_ready) begin
                if (bidx < 7) begin bq[bidx] = fl_byte; bc[bidx] = fl_is_cmd; end
                bidx++;
            end
            if (sq_req) begin
                if (rcnt == 0) begin
                    // R2 byte sequence of this page
                    if (bidx != 7 || bq[0] != 8'h00 || !bc[0] || bq[1] != 8'h00 || bc[1] ||
                        bq[2] != 8'h00 || bc[2] || bc[3] || bc[4] || bc[5] ||
                        bq[6] != 8'h30 || !bc[6]) seq_bad++;
                    cur = {8'h00, bq[5], bq[4], bq[3]};
                    if (cur >= NPG) begin seq_bad++; cur = 0; end
                    bidx = 0;
                end
                if (rcnt < NW) begin
                    sq_word_valid = 1'b1;
                    sq_word = {cur[15:0], 16'(rcnt)};
                    #1;
                    if (rcnt == 0) begin
                        first_addr = mem_addr;
                        if (n_log < LOGN) begin
                            page_log[n_log] = cur;
                            addr_log[n_log] = mem_addr;
                        end
                        n_log++;
                    end
                    if (!mem_we || mem_addr != first_addr + 32'(4 * rcnt) || mem_wdata != sq_word)
                        seq_bad++;
                    rcnt++;
                end else if (rcnt == NW) begin
                    sq_word_valid = 1'b0;
                    sq_done = 1'b1;
                    sq_ok = !fail_pg[cur];
                    sq_spare0 = (mark0[cur] || fail_pg[cur]) ? 8'h00 : 8'hFF;
                    sq_spare1 = mark1[cur] ? 8'h7F : 8'hFF;
                    rcnt++;
                end else begin
                    sq_done = 1'b0;
                end
            end else begin
                rcnt = 0;
                sq_done = 1'b0;
                sq_word_valid = 1'b0;
            end
        end
    end

    task automatic clear_map();
        for (int i = 0; i < NPG; i++) begin
            fail_pg[i] = 0; mark0[i] = 0; mark1[i] = 0;
        end
        stall_en = 0;
    endtask

    task automatic run(input logic [31:0] offs, input logic [31:0] size, input logic [31:0] dst,
                       input bit poke, output logic [1:0] st);
        int cyc;
        n_log = 0; seq_bad = 0; bidx = 0;
        @(negedge clk);
        img_offset = offs; img_size = size; dst_base = dst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 30000) begin
            if (poke && cyc == 50) begin
                img_offset = 32'h0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, "R10 done seen before timeout", done, 1);
        st = status;
        @(negedge clk);
        chk(!done, "R10 done lasts one cycle", done, 0);
        chk(seq_bad == 0, "R2/R3 byte sequence and write addresses", seq_bad, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fl_valid && !sq_req && !mem_we, "R1 idle after reset",
            {busy, done, fl_valid, sq_req, mem_we}, 0);
    endtask

    task automatic t_simple();
        logic [1:0] st;
        clear_map();
        run(32'h1000, 32'd5000, 32'h0002_0000, 0, st);
        chk(st == 2'd0, "R8 status ok", st, 0);
        chk(n_log == 3, "R8 page count", n_log, 3);
        chk(page_log[0] == 2 && page_log[2] == 4, "R3 start page", page_log[0], 2);
        chk(addr_log[1] == 32'h0002_0800, "R3 page address", addr_log[1], 32'h0002_0800);
    endtask

    task automatic t_stall_two_blocks();
        logic [1:0] st;
        clear_map();
        stall_en = 1;
        run(32'(300 * 2048), 32'(2048 * 64 + 1), 32'h1000_0000, 1, st);
        chk(st == 2'd0, "R2 status ok with stalls", st, 0);
        chk(n_log == 65, "R8 partial last block", n_log, 65);
        chk(page_log[0] == 300 && page_log[1] == 301, "R10 start while busy ignored", page_log[1], 301);
        chk(page_log[64] == 364, "R6 second block page", page_log[64], 364);
        chk(addr_log[64] == 32'h1002_0000, "R3 second block address", addr_log[64], 32'h1002_0000);
    endtask

    task automatic t_marker();
        logic [1:0] st;
        clear_map();
        mark1[3] = 1;
        run(32'h0, 32'(2 * 131072), 32'h8000_0000, 0, st);
        chk(st == 2'd0, "R4 status ok", st, 0);
        chk(n_log == 132, "R4 block stops at marked page", n_log, 132);
        chk(page_log[3] == 3 && page_log[4] == 64, "R6 source moves by 64", page_log[4], 64);
        chk(addr_log[4] == 32'h8000_0000, "R6 destination reused after bad block", addr_log[4], 32'h8000_0000);
        chk(page_log[68] == 128 && addr_log[68] == 32'h8002_0000, "R6 good block advances", addr_log[68], 32'h8002_0000);
    endtask

    task automatic t_unreadable();
        logic [1:0] st;
        clear_map();
        fail_pg[64] = 1; fail_pg[65] = 1;
        run(32'(64 * 2048), 32'd4096, 32'h0000_4000, 0, st);
        chk(st == 2'd0, "R5 status ok", st, 0);
        chk(n_log == 4, "R5 page count", n_log, 4);
        chk(page_log[2] == 128 && addr_log[2] == 32'h0000_4000, "R5 unreadable block skipped", page_log[2], 128);
    endtask

    task automatic t_read_error();
        logic [1:0] st;
        clear_map();
        fail_pg[1] = 1;
        run(32'h0, 32'd6144, 32'h0, 0, st);
        chk(st == 2'd1, "R7 read error status", st, 1);
        chk(n_log == 3, "R7 pages read (failed spare ignored, R4)", n_log, 3);
    endtask

    task automatic t_exhaust();
        logic [1:0] st;
        clear_map();
        mark0[0] = 1;
        run(32'(500 * 2048), 32'(2 * 131072), 32'h0, 0, st);
        chk(st == 2'd2, "R9 source exhausted status", st, 2);
        chk(n_log == 12 && page_log[11] == 511, "R9 last page below limit", n_log, 12);
    endtask

    task automatic t_zero();
        logic [1:0] st;
        clear_map();
        run(32'h4000, 32'd0, 32'h0, 0, st);
        chk(st == 2'd0, "R8 zero length status", st, 0);
        chk(n_log == 0, "R8 zero length reads nothing", n_log, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_map();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_simple();
        t_stall_two_blocks();
        t_marker();
        t_unreadable();
        t_read_error();
        t_exhaust();
        t_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule